// File: doc/BRIEF.md
# Capture and Up/Down Auto-Reload Timer

This block is a 16-bit timer/counter with one companion register that serves as a capture latch or as a reload value, depending on the mode. It runs from the oscillator clock and makes its own machine-cycle strobe, one every `MC_DIV` clocks. In timer mode the count advances once per machine cycle. In counter mode it advances once per falling edge seen on the count pin. A second pin, the trigger pin, has two uses. In capture mode and in plain reload mode it is a falling-edge event input. When down counting is enabled, its level sets the count direction.

Software reaches the block through a plain register port. Writes take effect at the clock edge. Reads are combinational from the address. Two sticky flags, overflow and external event, drive the interrupt line. Both pins are expected to be synchronous to `clk`. Neither has any data stream, so there is no valid/ready handshake at the edge of the block.

Top module: `tmr_capreload`

## Requirements
- R1: The register map is as follows. Address 0 is control. Its bits are: bit 0 run, bit 1 counter mode (1 = count-pin edges), bit 2 reload mode (0 = capture), bit 3 trigger enable, bit 4 down-count enable, bit 6 overflow flag, bit 7 external flag; all other bits read 0. Address 1 is the count. Address 2 is the capture/reload register. Every writable value reads back as written.
- R2: After reset all registers read 0 and `irq_o` is low.
- R3: In timer mode the count rises by one every `MC_DIV` clocks. The first increment lands exactly `MC_DIV` clock edges after the edge that sets run.
- R4: In counter mode the count pin is sampled once per machine cycle. A high sample followed by a low sample adds one, on the clock edge after the second sample. A pin alternating every machine cycle therefore adds one per two machine cycles.
- R5: While run is clear, the count, the capture/reload register and the flags keep their values, except when software writes them.
- R6: In capture mode, a step from 0xFFFF wraps to 0x0000 and sets the overflow flag.
- R7: In capture mode with trigger enable set, a falling trigger edge copies the count into the capture register and sets the external flag. With trigger enable clear, the edge changes nothing.
- R8: If a count-pin edge and a trigger edge are sampled in the same machine cycle in capture mode, the capture holds the count from before that increment.
- R9: In reload mode with down counting off, a step from 0xFFFF loads the reload value and sets the overflow flag.
- R10: In reload mode with down counting off and trigger enable set, a falling trigger edge loads the reload value and sets the external flag. This load takes priority over a count step in the same cycle. The overflow flag is still set if that step would have wrapped.
- R11: With down counting on, a high trigger level counts up and a low level counts down. Counting down from a count equal to the reload value loads 0xFFFF. Counting up from 0xFFFF loads the reload value. Both events set the overflow flag and toggle the external flag.
- R12: With down counting on, the external flag does not raise `irq_o`, and trigger edges neither load nor set flags.
- R13: `irq_o` is high while the overflow flag, or the external flag outside down-count mode, is set. Flags stay set until software writes 0 to them at address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_pin_i | input | 1 | External count pin (counter mode) |
| trig_pin_i | input | 1 | Trigger edge input or count direction |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Interrupt request |

## Verification
Two events can fall in the same cycle, and both are tested.

- **Count step and trigger action.** In counter mode, the count pin and the trigger pin are dropped between the same pair of machine-cycle samples. Both edge pulses then reach the counter on one clock edge. In capture mode, the pass criterion is that the captured value is the count before the increment. In reload mode the count starts at 0xFFFF. The pass criterion there is that the reload value wins and both the overflow and external flags end up set.
- **Down-count mode.** A trigger fall here coincides with a down step. The check is that the count shows the step and not a reload.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_COUNT = 2'd1;
  localparam logic [1:0] ADDR_RC    = 2'd2;

  localparam int BIT_RUN   = 0;
  localparam int BIT_CTR   = 1;
  localparam int BIT_RLD   = 2;
  localparam int BIT_TRGEN = 3;
  localparam int BIT_DOWN  = 4;
  localparam int BIT_OVF   = 6;
  localparam int BIT_EXT   = 7;
endpackage

// File: rtl/tmr_mcycle.sv
// Machine-cycle strobe: one pulse every DIV clocks while enabled; restarts when disabled.
module tmr_mcycle #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pcnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) pcnt_q <= '0;
    else if (pcnt_q == LAST) pcnt_q <= '0;
    else pcnt_q <= pcnt_q + 1'b1;
  end

  assign tick_o = run_i && (pcnt_q == LAST);
endmodule

// File: rtl/tmr_edge_sense.sv
// Samples N pins on each strobe; flags a one-clock pulse for high-then-low samples.
module tmr_edge_sense #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] smp_q;

  for (genvar g = 0; g < N; g++) begin : g_pin
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        smp_q[g]  <= 1'b0;
        fall_o[g] <= 1'b0;
      end else if (tick_i) begin
        smp_q[g]  <= pin_i[g];
        fall_o[g] <= smp_q[g] & ~pin_i[g];
      end else begin
        fall_o[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tmr_core.sv
// Count register, capture/reload register and the two sticky flags.
module tmr_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload_mode_i,
  input  logic             trig_en_i,
  input  logic             down_en_i,
  input  logic             step_i,
  input  logic             trig_fall_i,
  input  logic             dir_up_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wd_i,
  input  logic             rc_we_i,
  input  logic [CNT_W-1:0] rc_wd_i,
  input  logic             flag_we_i,
  input  logic             ovf_wd_i,
  input  logic             ext_wd_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] rc_o,
  output logic             ovf_o,
  output logic             ext_o
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cnt_n;
  logic             ovf_set, ext_set, ext_tgl, cap_evt;
  logic             at_top, at_floor;

  assign at_top   = (count_o == TOP);
  assign at_floor = (count_o == rc_o);

  always_comb begin
    cnt_n   = count_o;
    ovf_set = 1'b0;
    ext_set = 1'b0;
    ext_tgl = 1'b0;
    cap_evt = 1'b0;
    if (!reload_mode_i) begin
      if (step_i) begin
        cnt_n   = count_o + 1'b1;
        ovf_set = at_top;
      end
      if (trig_fall_i && trig_en_i) begin
        cap_evt = 1'b1;
        ext_set = 1'b1;
      end
    end else if (!down_en_i) begin
      if (step_i) begin
        cnt_n   = at_top ? rc_o : count_o + 1'b1;
        ovf_set = at_top;
      end
      if (trig_fall_i && trig_en_i) begin
        cnt_n   = rc_o;
        ext_set = 1'b1;
      end
    end else if (step_i) begin
      if (dir_up_i) begin
        cnt_n = at_top ? rc_o : count_o + 1'b1;
        ovf_set = at_top;
        ext_tgl = at_top;
      end else begin
        cnt_n = at_floor ? TOP : count_o - 1'b1;
        ovf_set = at_floor;
        ext_tgl = at_floor;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_o <= '0;
      rc_o    <= '0;
      ovf_o   <= 1'b0;
      ext_o   <= 1'b0;
    end else begin
      count_o <= cnt_we_i ? cnt_wd_i : cnt_n;
      if (cap_evt)      rc_o <= count_o;
      else if (rc_we_i) rc_o <= rc_wd_i;
      ovf_o <= (flag_we_i ? ovf_wd_i : ovf_o) | ovf_set;
      ext_o <= ((flag_we_i ? ext_wd_i : ext_o) ^ ext_tgl) | ext_set;
    end
  end
endmodule

// File: rtl/tmr_capreload.sv
module tmr_capreload
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int MC_DIV = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_pin_i,
  input  logic             trig_pin_i,
  input  logic             reg_wr_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [CNT_W-1:0] reg_wdata_i,
  output logic [CNT_W-1:0] reg_rdata_o,
  output logic             irq_o
);
  localparam int PAD_W = CNT_W - 8;

  logic run_q, ctr_q, rld_q, trgen_q, down_q;
  logic ctl_we, cnt_we, rc_we;
  logic tick, step, trig_fall;
  logic [1:0] falls;
  logic [CNT_W-1:0] count_w, rc_w;
  logic ovf_w, ext_w;
  logic unused_wbits;

  assign ctl_we = reg_wr_i && (reg_addr_i == ADDR_CTRL);
  assign cnt_we = reg_wr_i && (reg_addr_i == ADDR_COUNT);
  assign rc_we  = reg_wr_i && (reg_addr_i == ADDR_RC);
  assign unused_wbits = ^{reg_wdata_i[CNT_W-1:8], reg_wdata_i[5]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      ctr_q   <= 1'b0;
      rld_q   <= 1'b0;
      trgen_q <= 1'b0;
      down_q  <= 1'b0;
    end else if (ctl_we) begin
      run_q   <= reg_wdata_i[BIT_RUN];
      ctr_q   <= reg_wdata_i[BIT_CTR];
      rld_q   <= reg_wdata_i[BIT_RLD];
      trgen_q <= reg_wdata_i[BIT_TRGEN];
      down_q  <= reg_wdata_i[BIT_DOWN];
    end
  end

  tmr_mcycle #(.DIV(MC_DIV)) mcyc_i (
    .clk(clk), .rst_n(rst_n), .run_i(run_q), .tick_o(tick)
  );

  tmr_edge_sense #(.N(2)) edge_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .pin_i({trig_pin_i, cnt_pin_i}), .fall_o(falls)
  );

  assign step      = run_q && (ctr_q ? falls[0] : tick);
  assign trig_fall = run_q && falls[1];

  tmr_core #(.CNT_W(CNT_W)) core_i (
    .clk(clk), .rst_n(rst_n),
    .reload_mode_i(rld_q), .trig_en_i(trgen_q), .down_en_i(down_q),
    .step_i(step), .trig_fall_i(trig_fall), .dir_up_i(trig_pin_i),
    .cnt_we_i(cnt_we), .cnt_wd_i(reg_wdata_i),
    .rc_we_i(rc_we), .rc_wd_i(reg_wdata_i),
    .flag_we_i(ctl_we), .ovf_wd_i(reg_wdata_i[BIT_OVF]), .ext_wd_i(reg_wdata_i[BIT_EXT]),
    .count_o(count_w), .rc_o(rc_w), .ovf_o(ovf_w), .ext_o(ext_w)
  );

  always_comb begin
    unique case (reg_addr_i)
      ADDR_CTRL:  reg_rdata_o = {{PAD_W{1'b0}}, ext_w, ovf_w, 1'b0, down_q,
                                 trgen_q, rld_q, ctr_q, run_q};
      ADDR_COUNT: reg_rdata_o = count_w;
      ADDR_RC:    reg_rdata_o = rc_w;
      default:    reg_rdata_o = '0;
    endcase
  end

  assign irq_o = ovf_w | (ext_w & ~(rld_q & down_q));
endmodule

// File: rtl/tmr_capreload_chk.sv
module tmr_capreload_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr_i,
  input logic [1:0]       reg_addr_i,
  input logic             run,
  input logic             rld,
  input logic             down,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] rc,
  input logic             ovf,
  input logic             ext,
  input logic             irq_o
);
  // R5: stopped and untouched, nothing moves
  a_r5_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !reg_wr_i) |=> ($stable(count) && $stable(rc) && $stable(ovf) && $stable(ext)));

  // R3: in capture mode the count never jumps by more than one
  a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !rld && !reg_wr_i) |=> ((count == $past(count)) || (count == $past(count) + 1'b1)));

  // R6: in capture mode overflow only rises out of 0xFFFF
  a_r6_ovf_from_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ovf) && !$past(reg_wr_i) && !rld) |-> ($past(count) == '1));

  // R7: an untouched capture register only changes with the external flag set
  a_r7_capture_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!rld && !$past(reg_wr_i) && (rc != $past(rc))) |-> ext);

  // R12: in down mode the external flag alone never interrupts
  a_r12_ext_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (rld && down && !ovf) |-> !irq_o);

  // R13: overflow flag is sticky until a control write
  a_r13_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(reg_wr_i && reg_addr_i == ADDR_CTRL)) |=> ovf);
endmodule

bind tmr_capreload tmr_capreload_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
  .run(run_q), .rld(rld_q), .down(down_q),
  .count(count_w), .rc(rc_w), .ovf(ovf_w), .ext(ext_w), .irq_o(irq_o)
);

// File: tb/tmr_capreload_tb_top.sv
module tmr_capreload_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_pin = 1'b1;
  logic        trig_pin = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int n = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  tmr_capreload dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_pin_i(cnt_pin), .trig_pin_i(trig_pin),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .irq_o(irq)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd_chk(string tag, logic [1:0] a, logic [15:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic irq_chk(string tag, logic exp);
    #1;
    chk(tag, {15'd0, irq}, {15'd0, exp});
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    n++;
    reg_wr = 1'b0;
  endtask

  task automatic adv_to(int m);
    while (n < m) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cnt_pin = 1'b1; trig_pin = 1'b1; reg_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset_and_map();
    do_reset();
    rd_chk("R2 ctrl", 2'd0, 16'h0000);
    rd_chk("R2 count", 2'd1, 16'h0000);
    rd_chk("R2 rc", 2'd2, 16'h0000);
    irq_chk("R2 irq", 1'b0);
    wr(2'd2, 16'hBEEF);
    wr(2'd0, 16'h001E);
    rd_chk("R1 rc readback", 2'd2, 16'hBEEF);
    rd_chk("R1 ctrl readback", 2'd0, 16'h001E);
  endtask

  task automatic t_timer_and_stop();
    do_reset();
    wr(2'd0, 16'h0001); n = 0;
    adv_to(6);  rd_chk("R3 before first tick", 2'd1, 16'd0);
    adv_to(12); rd_chk("R3 first tick", 2'd1, 16'd1);
    adv_to(66); rd_chk("R3 five ticks", 2'd1, 16'd5);
    wr(2'd0, 16'h0000);
    adv_to(110); rd_chk("R5 stopped count", 2'd1, 16'd5);
    wr(2'd1, 16'h0042);
    adv_to(150); rd_chk("R5 stopped after write", 2'd1, 16'h0042);
  endtask

  task automatic t_counter_rate();
    do_reset();
    wr(2'd0, 16'h0003); n = 0;
    for (int j = 0; j < 5; j++) begin
      adv_to(14 + 24 * j); cnt_pin = 1'b0;
      adv_to(26 + 24 * j); cnt_pin = 1'b1;
      rd_chk("R4 edge count", 2'd1, 16'(j + 1));
    end
    adv_to(140); rd_chk("R4 max rate total", 2'd1, 16'd5);
  endtask

  task automatic t_capture_wrap();
    do_reset();
    wr(2'd1, 16'hFFFE);
    wr(2'd0, 16'h0001); n = 0;
    adv_to(30);
    rd_chk("R6 wrapped count", 2'd1, 16'h0000);
    rd_chk("R6 ovf flag", 2'd0, 16'h0041);
    irq_chk("R13 irq from ovf", 1'b1);
    wr(2'd0, 16'h0001);
    rd_chk("R13 ovf cleared", 2'd0, 16'h0001);
    irq_chk("R13 irq dropped", 1'b0);
  endtask

  task automatic t_capture_trigger();
    do_reset();
    wr(2'd0, 16'h0009); n = 0;
    adv_to(26); trig_pin = 1'b0;
    adv_to(40);
    rd_chk("R7 captured", 2'd2, 16'd3);
    rd_chk("R7 ext flag", 2'd0, 16'h0089);
    irq_chk("R13 irq from ext", 1'b1);
    wr(2'd0, 16'h0001);
    trig_pin = 1'b1;
    adv_to(50); trig_pin = 1'b0;
    adv_to(64);
    rd_chk("R7 disabled no capture", 2'd2, 16'd3);
    rd_chk("R7 disabled no flag", 2'd0, 16'h0001);
    rd_chk("R7 count runs on", 2'd1, 16'd5);
  endtask

  task automatic t_coincident_capture();
    do_reset();
    wr(2'd0, 16'h000B); n = 0;
    adv_to(26); cnt_pin = 1'b0;
    adv_to(40); cnt_pin = 1'b1;
    rd_chk("R8 first edge", 2'd1, 16'd1);
    adv_to(50); cnt_pin = 1'b0; trig_pin = 1'b0;
    adv_to(64);
    rd_chk("R8 count after both", 2'd1, 16'd2);
    rd_chk("R8 capture pre-increment", 2'd2, 16'd1);
    rd_chk("R8 flags", 2'd0, 16'h008B);
  endtask

  task automatic t_reload_up();
    do_reset();
    wr(2'd2, 16'hFFF0);
    wr(2'd1, 16'hFFFE);
    wr(2'd0, 16'h0005); n = 0;
    adv_to(30);
    rd_chk("R9 reloaded", 2'd1, 16'hFFF0);
    rd_chk("R9 ovf", 2'd0, 16'h0045);
  endtask

  task automatic t_reload_trigger();
    do_reset();
    wr(2'd2, 16'h1000);
    wr(2'd0, 16'h000D); n = 0;
    adv_to(26); trig_pin = 1'b0;
    adv_to(40);
    rd_chk("R10 forced reload", 2'd1, 16'h1000);
    rd_chk("R10 ext only", 2'd0, 16'h008D);
    do_reset();
    wr(2'd2, 16'h0100);
    wr(2'd1, 16'hFFFF);
    wr(2'd0, 16'h000F); n = 0;
    adv_to(14); cnt_pin = 1'b0; trig_pin = 1'b0;
    adv_to(28);
    rd_chk("R10 trigger wins over step", 2'd1, 16'h0100);
    rd_chk("R10 both flags", 2'd0, 16'h00CF);
  endtask

  task automatic t_down();
    do_reset();
    trig_pin = 1'b0;
    wr(2'd2, 16'h0005);
    wr(2'd1, 16'h0007);
    wr(2'd0, 16'h0015); n = 0;
    adv_to(40);
    rd_chk("R11 underflow loads top", 2'd1, 16'hFFFF);
    rd_chk("R11 ovf and ext toggle", 2'd0, 16'h00D5);
    wr(2'd0, 16'h0095);
    rd_chk("R12 ext kept", 2'd0, 16'h0095);
    irq_chk("R12 ext no irq", 1'b0);
    trig_pin = 1'b1;
    adv_to(50);
    rd_chk("R11 up overflow reload", 2'd1, 16'h0005);
    rd_chk("R11 ext toggled back", 2'd0, 16'h0055);
    adv_to(74); trig_pin = 1'b0;
    adv_to(88);
    rd_chk("R12 trigger ignored count", 2'd1, 16'h0006);
    rd_chk("R12 trigger ignored flags", 2'd0, 16'h0055);
  endtask

  initial begin
    t_reset_and_map();
    t_timer_and_stop();
    t_counter_rate();
    t_capture_wrap();
    t_capture_trigger();
    t_coincident_capture();
    t_reload_up();
    t_reload_trigger();
    t_down();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule